// File: doc/BRIEF.md
# SPI Peripheral SLIP Port

This block sits on the edge of a packet switch and lets an external SPI controller exchange Ethernet frames with it. The controller owns the serial clock: it drives SCK, the active-low select and the controller-to-peripheral data line. The block drives the peripheral-to-controller line. Each data line carries one unbroken SLIP byte stream, shifted most significant bit first in whole bytes. Select pulses do not mark frames. A frame may span several select windows, and an outgoing frame may start on any byte of the return line.

Bytes from the controller are SLIP-decoded and handed to the switch as a byte stream with valid, ready, last and error. Frames from the switch are taken as a byte stream with valid, ready and last, then SLIP-encoded onto the return line. When no frame is waiting, the block sends the end token 0xC0 as idle fill. SCK, select and data are brought into the system clock through synchronizers and oversampled there, so the system clock must run at least four times faster than SCK. The clock polarity and phase come from an input, and mode 3 is the intended default.

Back-pressure rules:
- Toward the switch, a beat is held with `rx_valid` high and its fields stable until `rx_ready` is seen high at a clock edge. There is only one output register. The consumer must take each beat before the next SPI byte completes, because a later beat replaces an unaccepted one.
- From the switch, `tx_valid` and its fields must stay stable until `tx_ready` pulses. `tx_ready` is high for at most one cycle per byte that goes onto the line.

Top module: `spi_slip_port`

## Requirements
- R1: After reset `rx_valid` and `tx_ready` are low and `spi_cipo` is high, which is the first bit of the idle token 0xC0.
- R2: In each of the four modes, incoming bytes are assembled MSB first on the sampling edge. `spi_mode[1]` is the idle level of SCK and `spi_mode[0]` is the phase. Phase 0 samples on the edge leaving idle and phase 1 samples on the edge returning to idle. The return line is updated on the opposite edge.
- R3: Whenever no frame byte is pending, the return line carries 0xC0 bytes.
- R4: An outgoing frame is sent as its bytes in order, with these substitutions, and then a single 0xC0:
  - data 0xC0 is sent as 0xDB 0xDC;
  - data 0xDB is sent as 0xDB 0xDD.
- R5: Decoded data bytes leave in order. `rx_last` is set on the byte just before a delimiting 0xC0. A run of consecutive 0xC0 bytes yields no beat.
- R6: Incoming 0xDB 0xDC yields data 0xC0, and incoming 0xDB 0xDD yields data 0xDB.
- R7: An incoming 0xDB followed by any other byte discards the frame.
  - If no beat of that frame has left yet, nothing of the frame is output.
  - Otherwise the frame's final beat carries `rx_last` and `rx_error` together.
  - Bytes after the bad escape are ignored up to the next 0xC0.
- R8: Both streams continue unbroken across select deassertion. A frame split over several select windows is decoded and encoded exactly as if it were sent in one window.
- R9: Handshakes:
  - `rx_valid` and its fields stay stable until accepted;
  - `tx_ready` is asserted only together with `tx_valid`, and never for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_mode | input | 2 | [1] SCK idle level, [0] clock phase |
| spi_csn | input | 1 | Active-low select from controller |
| spi_sck | input | 1 | Serial clock from controller |
| spi_copi | input | 1 | Serial data from controller |
| spi_cipo | output | 1 | Serial data to controller |
| rx_data | output | 8 | Decoded byte toward the switch |
| rx_last | output | 1 | Final byte of a frame |
| rx_error | output | 1 | Frame ended by a bad escape (with rx_last) |
| rx_valid | output | 1 | rx beat present |
| rx_ready | input | 1 | Switch accepts rx beat |
| tx_data | input | 8 | Frame byte from the switch |
| tx_last | input | 1 | Final byte of the outgoing frame |
| tx_valid | input | 1 | tx beat present |
| tx_ready | output | 1 | tx beat consumed this cycle |

## Verification
The return line changes on the third clock edge after the shift edge of SCK: two synchronizer stages, then the shift register. The bench therefore reads `spi_cipo` a full half SCK period of eight system clocks after that edge, just before the controller's own sampling edge. A decoded beat shows up on the fourth clock edge after the sampling edge that ends the byte which releases it, which is the next data byte or the delimiter. The bench waits two half periods after every burst before it compares the beats it has logged. Beats are logged at falling clock edges whenever valid and ready are both high, and return bytes are compared against a bench-built SLIP encoding. Each comparison is made only once the whole byte stream for the case has been clocked through.

// File: rtl/spi_slip_pkg.sv
package spi_slip_pkg;
  localparam int SLIP_W = 8;
  localparam logic [SLIP_W-1:0] TOK_END     = 8'hC0;
  localparam logic [SLIP_W-1:0] TOK_ESC     = 8'hDB;
  localparam logic [SLIP_W-1:0] TOK_ESC_END = 8'hDC;
  localparam logic [SLIP_W-1:0] TOK_ESC_ESC = 8'hDD;

  typedef enum logic [1:0] {
    ENC_DATA = 2'd0,
    ENC_ESC  = 2'd1,
    ENC_END  = 2'd2
  } enc_state_t;
endpackage

// File: rtl/spi_slip_sync.sv
module spi_slip_sync #(
  parameter int STAGES = 2,
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_slip_phy.sv
module spi_slip_phy
  import spi_slip_pkg::*;
#(
  parameter int BYTE_W = SLIP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              csn_s,
  input  logic              sck_s,
  input  logic              copi_s,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_stb,
  output logic              load_req,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              cipo
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(BYTE_W - 1);

  logic              sck_q, csn_q, primed;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              rise, fall, lead, trail, active, samp, shft, cs_fall;

  always_comb begin
    rise     = sck_s & ~sck_q;
    fall     = ~sck_s & sck_q;
    lead     = mode[1] ? fall : rise;
    trail    = mode[1] ? rise : fall;
    active   = ~csn_s;
    samp     = active & (mode[0] ? trail : lead);
    shft     = active & (mode[0] ? lead : trail);
    cs_fall  = csn_q & ~csn_s;
    load_req = (shft && cnt == '0) || (cs_fall && !mode[0] && !primed);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      csn_q   <= 1'b1;
      cnt     <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      rx_stb  <= 1'b0;
      tx_sh   <= TOK_END;
      primed  <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      csn_q  <= csn_s;
      rx_stb <= samp && cnt == CNT_TOP;
      if (!active) begin
        cnt <= '0;
      end else if (samp) begin
        cnt     <= (cnt == CNT_TOP) ? '0 : cnt + 1'b1;
        rx_sh   <= {rx_sh[BYTE_W-2:0], copi_s};
        rx_byte <= {rx_sh[BYTE_W-2:0], copi_s};
      end
      if (load_req) tx_sh <= tx_byte;
      else if (shft) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      if (load_req) primed <= 1'b1;
      else if (samp) primed <= 1'b0;
    end
  end

  assign cipo = tx_sh[BYTE_W-1];
endmodule

// File: rtl/slip_rx_decoder.sv
module slip_rx_decoder
  import spi_slip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLIP_W-1:0] in_byte,
  input  logic              in_stb,
  output logic [SLIP_W-1:0] m_data,
  output logic              m_last,
  output logic              m_err,
  output logic              m_valid,
  input  logic              m_ready
);
  logic [SLIP_W-1:0] pend, dat_val;
  logic have, started, esc, drop;
  logic dat_en, end_en, err_en, esc_en, push_en;

  always_comb begin
    dat_en = 1'b0; end_en = 1'b0; err_en = 1'b0; esc_en = 1'b0;
    dat_val = in_byte;
    if (in_stb && !drop) begin
      if (esc) begin
        if (in_byte == TOK_ESC_END) begin dat_en = 1'b1; dat_val = TOK_END; end
        else if (in_byte == TOK_ESC_ESC) begin dat_en = 1'b1; dat_val = TOK_ESC; end
        else err_en = 1'b1;
      end else if (in_byte == TOK_END) end_en = 1'b1;
      else if (in_byte == TOK_ESC) esc_en = 1'b1;
      else dat_en = 1'b1;
    end
    push_en = ((dat_en || end_en) && have) || (err_en && started);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; have <= 1'b0; started <= 1'b0; esc <= 1'b0; drop <= 1'b0;
      m_data <= '0; m_last <= 1'b0; m_err <= 1'b0; m_valid <= 1'b0;
    end else begin
      if (push_en) begin
        m_data  <= pend;
        m_last  <= end_en || err_en;
        m_err   <= err_en;
        m_valid <= 1'b1;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
      if (in_stb && drop && in_byte == TOK_END) drop <= 1'b0;
      if (esc_en) esc <= 1'b1;
      else if (dat_en || err_en) esc <= 1'b0;
      if (dat_en) begin
        pend <= dat_val;
        have <= 1'b1;
        if (have) started <= 1'b1;
      end
      if (end_en || err_en) begin
        have    <= 1'b0;
        started <= 1'b0;
      end
      if (err_en && in_byte != TOK_END) drop <= 1'b1;
    end
  end
endmodule

// File: rtl/slip_tx_encoder.sv
module slip_tx_encoder
  import spi_slip_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  output logic [SLIP_W-1:0] out_byte,
  input  logic [SLIP_W-1:0] s_data,
  input  logic              s_last,
  input  logic              s_valid,
  output logic              s_ready
);
  enc_state_t st, nxt;
  logic special;

  always_comb begin
    special  = (s_data == TOK_END) || (s_data == TOK_ESC);
    out_byte = TOK_END;
    s_ready  = 1'b0;
    nxt      = st;
    case (st)
      ENC_ESC: begin
        out_byte = (s_data == TOK_END) ? TOK_ESC_END : TOK_ESC_ESC;
        if (load_req) begin
          s_ready = 1'b1;
          nxt = s_last ? ENC_END : ENC_DATA;
        end
      end
      ENC_END: begin
        if (load_req) nxt = ENC_DATA;
      end
      default: begin
        if (s_valid) begin
          if (special) begin
            out_byte = TOK_ESC;
            if (load_req) nxt = ENC_ESC;
          end else begin
            out_byte = s_data;
            if (load_req) begin
              s_ready = 1'b1;
              nxt = s_last ? ENC_END : ENC_DATA;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ENC_DATA;
    else st <= nxt;
  end
endmodule

// File: rtl/spi_slip_port.sv
module spi_slip_port
  import spi_slip_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        spi_mode,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_copi,
  output logic              spi_cipo,
  output logic [SLIP_W-1:0] rx_data,
  output logic              rx_last,
  output logic              rx_error,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [SLIP_W-1:0] tx_data,
  input  logic              tx_last,
  input  logic              tx_valid,
  output logic              tx_ready
);
  logic [2:0] pins_s;
  logic [SLIP_W-1:0] rx_byte, tx_byte;
  logic rx_stb, load_req;

  spi_slip_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_csn, spi_sck, spi_copi}), .q(pins_s)
  );

  spi_slip_phy #(.BYTE_W(SLIP_W)) u_phy (
    .clk(clk), .rst_n(rst_n), .mode(spi_mode),
    .csn_s(pins_s[2]), .sck_s(pins_s[1]), .copi_s(pins_s[0]),
    .rx_byte(rx_byte), .rx_stb(rx_stb),
    .load_req(load_req), .tx_byte(tx_byte), .cipo(spi_cipo)
  );

  slip_rx_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .in_byte(rx_byte), .in_stb(rx_stb),
    .m_data(rx_data), .m_last(rx_last), .m_err(rx_error),
    .m_valid(rx_valid), .m_ready(rx_ready)
  );

  slip_tx_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .out_byte(tx_byte),
    .s_data(tx_data), .s_last(tx_last), .s_valid(tx_valid), .s_ready(tx_ready)
  );
endmodule

// File: rtl/spi_slip_port_chk.sv
module spi_slip_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_data,
  input logic       rx_last,
  input logic       rx_error,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] tx_data,
  input logic       tx_last,
  input logic       tx_valid,
  input logic       tx_ready
);
  // R9: an unaccepted rx beat is held
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_last) && $stable(rx_error));

  // R9: tx consumption only with a valid beat
  a_r9_tx_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_valid);

  // R9: at most one byte taken per line byte
  a_r9_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);

  // R9: source keeps its beat until consumed
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R7: an error beat always closes its frame
  a_r7_err_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_error |-> rx_last);
endmodule

bind spi_slip_port spi_slip_port_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_data(rx_data), .rx_last(rx_last), .rx_error(rx_error),
  .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .tx_valid(tx_valid), .tx_ready(tx_ready)
);

// File: tb/spi_slip_port_test.sv
`timescale 1ns/1ps
module spi_slip_port_test;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic [1:0] spi_mode = 2'd3;
  logic spi_csn = 1, spi_sck = 1, spi_copi = 1;
  logic spi_cipo;
  logic [7:0] rx_data;
  logic rx_last, rx_error, rx_valid, tx_ready;
  logic rx_ready = 1;
  logic [7:0] tx_data;
  logic tx_last, tx_valid;

  int checks = 0, errors = 0;
  logic [7:0] mo [0:1023]; int mo_n;
  logic [7:0] mi [0:1023]; int mi_n;
  logic [7:0] rxd [0:1023]; logic rxl [0:1023]; logic rxe [0:1023]; int rx_n = 0;
  logic [7:0] txf [0:2047]; logic txl [0:2047]; int tx_len = 0; int tx_idx = 0;
  logic [7:0] fr [0:511]; int fr_n;
  logic [7:0] ex [0:1023]; int ex_n;
  logic [7:0] ed [0:511]; logic el [0:511]; logic ee [0:511]; int e_n;
  bit stall_on = 0;

  always #5 clk = ~clk;

  spi_slip_port uut (
    .clk(clk), .rst_n(rst_n), .spi_mode(spi_mode), .spi_csn(spi_csn),
    .spi_sck(spi_sck), .spi_copi(spi_copi), .spi_cipo(spi_cipo),
    .rx_data(rx_data), .rx_last(rx_last), .rx_error(rx_error),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  assign tx_valid = tx_idx < tx_len;
  assign tx_data  = txf[tx_idx];
  assign tx_last  = txl[tx_idx];

  always @(posedge clk) if (tx_ready) tx_idx <= tx_idx + 1;

  always @(negedge clk) if (rst_n && rx_valid && rx_ready) begin
    rxd[rx_n] = rx_data; rxl[rx_n] = rx_last; rxe[rx_n] = rx_error; rx_n = rx_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    mo[mo_n] = b; mo_n++;
  endtask

  task automatic put_enc(input logic [7:0] b);
    if (b == 8'hC0) begin put(8'hDB); put(8'hDC); end
    else if (b == 8'hDB) begin put(8'hDB); put(8'hDD); end
    else put(b);
  endtask

  task automatic put_frame();
    put(8'hC0);
    for (int i = 0; i < fr_n; i++) put_enc(fr[i]);
    put(8'hC0);
  endtask

  // queue fr as outgoing frame and build its expected encoding in ex
  task automatic queue_tx();
    ex_n = 0;
    for (int i = 0; i < fr_n; i++) begin
      txf[tx_len + i] = fr[i];
      txl[tx_len + i] = (i == fr_n - 1);
      if (fr[i] == 8'hC0) begin ex[ex_n] = 8'hDB; ex[ex_n+1] = 8'hDC; ex_n += 2; end
      else if (fr[i] == 8'hDB) begin ex[ex_n] = 8'hDB; ex[ex_n+1] = 8'hDD; ex_n += 2; end
      else begin ex[ex_n] = fr[i]; ex_n++; end
    end
    ex[ex_n] = 8'hC0; ex_n++;
    tx_len = tx_len + fr_n;
  endtask

  task automatic set_mode(input logic [1:0] m);
    spi_csn = 1; waitc(2);
    spi_mode = m; spi_sck = m[1];
    waitc(4);
  endtask

  task automatic spi_byte(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      if (!spi_mode[0]) begin
        spi_copi = b[i]; waitc(H);
        r[i] = spi_cipo; spi_sck = ~spi_mode[1]; waitc(H);
        spi_sck = spi_mode[1];
      end else begin
        spi_sck = ~spi_mode[1]; spi_copi = b[i]; waitc(H);
        r[i] = spi_cipo; spi_sck = spi_mode[1]; waitc(H);
      end
    end
    mi[mi_n] = r; mi_n++;
  endtask

  task automatic burst(input int from, input int to);
    spi_csn = 0; waitc(2*H);
    for (int i = from; i < to; i++) spi_byte(mo[i]);
    waitc(H); spi_csn = 1; waitc(2*H);
  endtask

  task automatic check_rx(input string tag);
    bit ok = (rx_n == e_n);
    int bad = -1;
    for (int i = 0; i < e_n && i < rx_n; i++)
      if (rxd[i] != ed[i] || rxl[i] != el[i] || rxe[i] != ee[i]) begin ok = 0; if (bad < 0) bad = i; end
    if (bad >= 0)
      chk(0, tag, {rxd[bad], 3'b0, rxl[bad], 3'b0, rxe[bad]}, {ed[bad], 3'b0, el[bad], 3'b0, ee[bad]});
    else
      chk(ok, {tag, " beat count"}, rx_n, e_n);
  endtask

  task automatic check_tx(input string tag);
    int k = 0, bad = -1;
    while (k < mi_n && mi[k] == 8'hC0) k++;
    if (k + ex_n > mi_n) begin chk(0, {tag, " short"}, mi_n - k, ex_n); return; end
    for (int i = 0; i < ex_n; i++) if (bad < 0 && mi[k+i] != ex[i]) bad = i;
    if (bad >= 0) begin chk(0, tag, mi[k+bad], ex[bad]); return; end
    for (int i = k + ex_n; i < mi_n; i++) if (bad < 0 && mi[i] != 8'hC0) bad = i;
    if (bad >= 0) chk(0, {tag, " idle after"}, mi[bad], 8'hC0);
    else chk(1, tag, 0, 0);
  endtask

  task automatic expect_frame();
    e_n = fr_n;
    for (int i = 0; i < fr_n; i++) begin ed[i] = fr[i]; el[i] = (i == fr_n - 1); ee[i] = 0; end
  endtask

  task automatic clear();
    mo_n = 0; mi_n = 0; rx_n = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitc(10); rst_n = 1; waitc(2);
    // R1 reset state
    chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    chk(tx_ready == 0, "R1 tx_ready", tx_ready, 0);
    chk(spi_cipo == 1, "R1 cipo idle bit", spi_cipo, 1);

    // R3 idle fill and R5 no empty frames from repeated 0xC0
    clear(); set_mode(2'd3);
    for (int i = 0; i < 4; i++) put(8'hC0);
    burst(0, mo_n);
    begin
      bit ok = 1;
      for (int i = 0; i < mi_n; i++) if (mi[i] != 8'hC0) ok = 0;
      chk(ok && mi_n == 4, "R3 idle fill", mi[0], 8'hC0);
    end
    chk(rx_n == 0, "R5 no empty frames", rx_n, 0);

    // R2 R4 R5 R6 in every mode
    for (int m = 0; m < 4; m++) begin
      clear(); set_mode(m[1:0]);
      fr_n = 8;
      for (int i = 0; i < fr_n; i++) fr[i] = 8'(i*29 + m*7 + 1);
      fr[1] = 8'hDB; fr[3] = 8'hC0;
      queue_tx();
      fr_n = 10;
      for (int i = 0; i < fr_n; i++) fr[i] = 8'(i*53 + m*17 + 3);
      fr[2] = 8'hC0; fr[5] = 8'hDB;
      put_frame();
      for (int i = 0; i < 6; i++) put(8'hC0);
      burst(0, mo_n);
      expect_frame();
      check_rx($sformatf("R2 R5 R6 rx frame mode %0d", m));
      check_tx($sformatf("R4 R3 tx frame mode %0d", m));
    end

    // all 256 byte values, both directions, mode 3
    clear(); set_mode(2'd3);
    fr_n = 256;
    for (int i = 0; i < 256; i++) fr[i] = 8'(255 - i);
    queue_tx();
    for (int i = 0; i < 256; i++) fr[i] = 8'(i);
    put_frame();
    for (int i = 0; i < 4; i++) put(8'hC0);
    burst(0, mo_n);
    expect_frame();
    check_rx("R6 R5 all byte values rx");
    check_tx("R4 all byte values tx");

    // R7 bad escape after beats left, then tail ignored, then good frame
    clear();
    put(8'hC0); put(8'h11); put(8'h22); put(8'hDB); put(8'h55);
    put(8'h33); put(8'h44); put(8'hC0); put(8'h66); put(8'hC0);
    burst(0, mo_n);
    e_n = 3;
    ed[0] = 8'h11; el[0] = 0; ee[0] = 0;
    ed[1] = 8'h22; el[1] = 1; ee[1] = 1;
    ed[2] = 8'h66; el[2] = 1; ee[2] = 0;
    check_rx("R7 bad escape mid frame");

    // R7 bad escape before any beat left: nothing output
    clear();
    put(8'hC0); put(8'h77); put(8'hDB); put(8'h12); put(8'h34); put(8'hC0); put(8'hC0);
    burst(0, mo_n);
    chk(rx_n == 0, "R7 early bad escape drops frame", rx_n, 0);

    // R8 frames straddling select gaps, R9 with rx stalls
    clear();
    fr_n = 6;
    for (int i = 0; i < fr_n; i++) fr[i] = 8'(8'hA0 + i);
    fr[4] = 8'hC0;
    queue_tx();
    for (int i = 0; i < fr_n; i++) fr[i] = 8'(8'h40 + 3*i);
    fr[2] = 8'hDB;
    put_frame();
    for (int i = 0; i < 4; i++) put(8'hC0);
    stall_on = 1;
    fork
      begin
        burst(0, 3); burst(3, 5); burst(5, mo_n);
        stall_on = 0;
      end
      begin
        while (stall_on) begin
          waitc(30); rx_ready = 0; waitc(10); rx_ready = 1;
        end
      end
    join
    rx_ready = 1;
    expect_frame();
    check_rx("R8 R9 rx across select gaps");
    check_tx("R8 tx across select gaps");
    chk(tx_idx == tx_len, "R9 all tx bytes consumed", tx_idx, tx_len);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule